// File: doc/BRIEF.md
# Lock-Level Access Guard for Code Memory Verify and Programming

This block sits between a programming and verify port and the on-chip code memory. It owns the code memory, a 128-byte key bank, a small configuration bank and a 3-bit lock field. The lock field is decoded into a security level from 0 to 3. Each level adds restrictions to those of the level below it. Every request on the port is checked against that level and is either carried out or refused.

A refused request leaves all storage unchanged. It raises a single-cycle refusal flag, and a refused read returns all ones. A verify read of code returns the stored byte XNORed with a key byte. The key byte is picked by the low seven address bits, so an erased key (all ones) returns the code unchanged. A table read from the running program always returns plain code. A separate erase input is the only way to lower the lock level again. The block also drives an enable for execution from external memory.

Top module: `lock_guard_top`

## Requirements
- R1: The `level` output follows the lock field: 000 gives 0, 001 gives 1, 01x gives 2 and 1xx gives 3. After reset the lock field is 000.
- R2: At level 0 every request is granted. `req_op` encodings are: 0 program code, 1 program configuration, 2 program key, 3 program lock, 4 verify code, 5 read configuration, 6 read lock, 7 table read.
- R3: At level 1 and above, a request to program code, configuration or key is refused. Storage stays unchanged and `access_denied` is set.
- R4: At level 2 and above, a verify read is refused. It returns 8'hFF with `rsp_valid` and `access_denied` both set.
- R5: `ext_exec_en` is low at level 3 and high at levels 0 to 2.
- R6: Reads of configuration bytes (index = `req_addr[CFG_AW-1:0]`) and of the lock field are granted at every level. A lock read returns the lock field in `rsp_data[2:0]`.
- R7: A granted verify returns `~(code[addr] ^ key[addr[6:0]])`. With the key still erased, this equals the plain code byte.
- R8: A table read is granted at every level and returns the plain code byte.
- R9: Programming the lock field is granted only when the written value decodes to a level equal to or above the current level. Otherwise it is refused and the field is kept.
- R10: `erase_req` sets all code, key and configuration bytes to 8'hFF and the lock field to 000. It takes priority over a request in the same cycle, which is then dropped with no response and no refusal.
- R11: The results of a request sampled at a rising edge appear right after that edge and last one cycle. `rsp_valid` is set for ops 4 to 7, and `access_denied` is set only for a refused request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, storage to erased state |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request operation code |
| req_addr | input | CODE_AW | Byte address (code, key and configuration index) |
| req_wdata | input | 8 | Write data for programming requests |
| erase_req | input | 1 | Full erase of all storage and the lock field |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 8 | Read response byte |
| access_denied | output | 1 | One-cycle flag for a refused request |
| level | output | 2 | Current security level |
| ext_exec_en | output | 1 | Execution from external memory allowed |

## Verification
All response outputs are registered. A request driven before rising edge N shows its `rsp_valid`, `rsp_data` and `access_denied` between edges N and N+1. Any write or lock change from that request is visible in `level`, `ext_exec_en` and later reads from that same point. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and compares at the next falling edge against a bench-side model of the storage and the lock field. Idle cycles after refusals confirm that the flag drops again one cycle later.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;

  typedef enum logic [2:0] {
    OP_PROG_CODE  = 3'd0,
    OP_PROG_CFG   = 3'd1,
    OP_PROG_KEY   = 3'd2,
    OP_PROG_LOCK  = 3'd3,
    OP_VERIFY     = 3'd4,
    OP_READ_CFG   = 3'd5,
    OP_READ_LOCK  = 3'd6,
    OP_TABLE_READ = 3'd7
  } lg_op_e;

  // Lock field to security level, highest set bit wins
  function automatic logic [1:0] lock_to_level(input logic [2:0] lb);
    if (lb[2])      return 2'd3;
    else if (lb[1]) return 2'd2;
    else if (lb[0]) return 2'd1;
    else            return 2'd0;
  endfunction

  // Verify obfuscation: bitwise equivalence of code and key
  function automatic logic [7:0] mask_byte(input logic [7:0] code, input logic [7:0] key);
    return ~(code ^ key);
  endfunction

endpackage

// File: rtl/lg_level_decode.sv
module lg_level_decode
  import lock_guard_pkg::*;
(
  input  logic [2:0] lock_bits,
  output logic [1:0] level
);
  always_comb level = lock_to_level(lock_bits);
endmodule

// File: rtl/lg_access_policy.sv
module lg_access_policy
  import lock_guard_pkg::*;
(
  input  lg_op_e     op,
  input  logic [1:0] cur_level,
  input  logic [1:0] new_level,
  output logic       allow,
  output logic       is_read,
  output logic       ext_exec_en
);
  always_comb begin
    unique case (op)
      OP_PROG_CODE,
      OP_PROG_CFG,
      OP_PROG_KEY:   allow = (cur_level == 2'd0);
      OP_PROG_LOCK:  allow = (new_level >= cur_level);
      OP_VERIFY:     allow = (cur_level < 2'd2);
      default:       allow = 1'b1;
    endcase
    is_read     = op[2];
    ext_exec_en = (cur_level != 2'd3);
  end
endmodule

// File: rtl/lg_byte_bank.sv
module lg_byte_bank #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/lock_guard_top.sv
module lock_guard_top
  import lock_guard_pkg::*;
#(
  parameter int CODE_AW   = 8,
  parameter int KEY_DEPTH = 128,
  parameter int CFG_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [CODE_AW-1:0] req_addr,
  input  logic [7:0]         req_wdata,
  input  logic               erase_req,
  output logic               rsp_valid,
  output logic [7:0]         rsp_data,
  output logic               access_denied,
  output logic [1:0]         level,
  output logic               ext_exec_en
);
  localparam int CODE_DEPTH = 1 << CODE_AW;
  localparam int KEY_AW     = $clog2(KEY_DEPTH);
  localparam int CFG_AW     = $clog2(CFG_DEPTH);

  lg_op_e     op_w;
  logic [2:0] lock_q;
  logic [1:0] new_level;
  logic       allow, is_read, fire;
  logic       code_we, cfg_we, key_we, lock_we;
  logic [7:0] code_rd, key_rd, cfg_rd, rd_sel;
  logic       rsp_valid_q, denied_q;
  logic [7:0] rsp_data_q;

  assign op_w = lg_op_e'(req_op);
  assign fire = req_valid && !erase_req;

  lg_level_decode u_cur_dec (.lock_bits(lock_q),         .level(level));
  lg_level_decode u_new_dec (.lock_bits(req_wdata[2:0]), .level(new_level));

  lg_access_policy u_policy (
    .op(op_w), .cur_level(level), .new_level(new_level),
    .allow(allow), .is_read(is_read), .ext_exec_en(ext_exec_en)
  );

  // Internal events, named for the assertions
  assign code_we = fire && allow && (op_w == OP_PROG_CODE);
  assign cfg_we  = fire && allow && (op_w == OP_PROG_CFG);
  assign key_we  = fire && allow && (op_w == OP_PROG_KEY);
  assign lock_we = fire && allow && (op_w == OP_PROG_LOCK);

  lg_byte_bank #(.DEPTH(CODE_DEPTH), .AW(CODE_AW)) u_code (
    .clk(clk), .rst_n(rst_n), .erase(erase_req), .we(code_we),
    .waddr(req_addr), .wdata(req_wdata), .raddr(req_addr), .rdata(code_rd)
  );
  lg_byte_bank #(.DEPTH(KEY_DEPTH), .AW(KEY_AW)) u_key (
    .clk(clk), .rst_n(rst_n), .erase(erase_req), .we(key_we),
    .waddr(req_addr[KEY_AW-1:0]), .wdata(req_wdata),
    .raddr(req_addr[KEY_AW-1:0]), .rdata(key_rd)
  );
  lg_byte_bank #(.DEPTH(CFG_DEPTH), .AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .erase(erase_req), .we(cfg_we),
    .waddr(req_addr[CFG_AW-1:0]), .wdata(req_wdata),
    .raddr(req_addr[CFG_AW-1:0]), .rdata(cfg_rd)
  );

  always_comb begin
    unique case (op_w)
      OP_VERIFY:     rd_sel = mask_byte(code_rd, key_rd);
      OP_READ_CFG:   rd_sel = cfg_rd;
      OP_READ_LOCK:  rd_sel = {5'b0, lock_q};
      OP_TABLE_READ: rd_sel = code_rd;
      default:       rd_sel = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q      <= 3'b000;
      rsp_valid_q <= 1'b0;
      denied_q    <= 1'b0;
      rsp_data_q  <= 8'hFF;
    end else begin
      if (erase_req)    lock_q <= 3'b000;
      else if (lock_we) lock_q <= req_wdata[2:0];
      rsp_valid_q <= fire && is_read;
      denied_q    <= fire && !allow;
      rsp_data_q  <= (fire && allow) ? rd_sel : 8'hFF;
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;
  assign access_denied = denied_q;

  // Assertions next to the logic they guard
  AST_PROG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (req_op < 3'd3) && (level != 2'd0)) |=> access_denied); // R3
  AST_VERIFY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (req_op == 3'd4) && (level >= 2'd2)) |=> (access_denied && rsp_valid)); // R4
  AST_DENY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && access_denied) |-> (rsp_data == 8'hFF)); // R4
  AST_EXT_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'd3) |-> !ext_exec_en); // R5
  AST_TABLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (req_op == 3'd7)) |=> (rsp_valid && !access_denied)); // R8
  AST_LEVEL_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_req |=> (level >= $past(level))); // R9
  AST_ERASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> ((level == 2'd0) && !rsp_valid && !access_denied)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !access_denied)); // R11
endmodule

// File: tb/lock_guard_top_tb.sv
module lock_guard_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = 8'h00;
  logic          erase_req = 1'b0;
  logic          rsp_valid, access_denied, ext_exec_en;
  logic [7:0]    rsp_data;
  logic [1:0]    level;

  int checks = 0;
  int errors = 0;

  logic [7:0] code_m [256];
  logic [7:0] key_m  [128];
  logic [7:0] cfg_m  [4];
  logic [2:0] lb_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_guard_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .erase_req(erase_req),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .access_denied(access_denied),
    .level(level), .ext_exec_en(ext_exec_en)
  );

  // Bench restatement of the level table
  function automatic int lvl_of(input logic [2:0] lb);
    if (lb == 3'b000) return 0;
    if (lb == 3'b001) return 1;
    if (lb[2] == 1'b0) return 2;
    return 3;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd2: return "R3";
      3'd3:             return "R9";
      3'd4:             return "R7";
      3'd7:             return "R8";
      default:          return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_erase();
    for (int i = 0; i < 256; i++) code_m[i] = 8'hFF;
    for (int i = 0; i < 128; i++) key_m[i]  = 8'hFF;
    for (int i = 0; i < 4; i++)   cfg_m[i]  = 8'hFF;
    lb_m = 3'b000;
  endtask

  task automatic check_state();
    chk("R1", int'(level), lvl_of(lb_m));
    chk("R5", int'(ext_exec_en), (lvl_of(lb_m) != 3) ? 1 : 0);
  endtask

  task automatic do_req(input logic [2:0] op, input logic [7:0] addr,
                        input logic [7:0] wd, input string tag_in);
    int lv = lvl_of(lb_m);
    bit allow;
    bit rd = op[2];
    logic [7:0] exp_d;
    string tag = (tag_in == "") ? tag_of(op) : tag_in;
    case (op)
      3'd0, 3'd1, 3'd2: allow = (lv == 0);
      3'd3:             allow = (lvl_of(wd[2:0]) >= lv);
      3'd4:             allow = (lv < 2);
      default:          allow = 1'b1;
    endcase
    case (op)
      3'd4:    exp_d = ~(code_m[addr] ^ key_m[addr[6:0]]);
      3'd5:    exp_d = cfg_m[addr[1:0]];
      3'd6:    exp_d = {5'b0, lb_m};
      3'd7:    exp_d = code_m[addr];
      default: exp_d = 8'hFF;
    endcase
    if (!allow) exp_d = 8'hFF;
    if (op == 3'd4 && !allow && tag_in == "") tag = "R4";
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (allow) begin
      case (op)
        3'd0: code_m[addr] = wd;
        3'd1: cfg_m[addr[1:0]] = wd;
        3'd2: key_m[addr[6:0]] = wd;
        3'd3: lb_m = wd[2:0];
        default: ;
      endcase
    end
    chk("R11", int'(rsp_valid), int'(rd));
    chk(tag, int'(access_denied), allow ? 0 : 1);
    if (rd) begin
      if (op == 3'd6) chk(tag, int'(rsp_data[2:0]), int'(exp_d[2:0]));
      else            chk(tag, int'(rsp_data), int'(exp_d));
    end
    check_state();
  endtask

  task automatic do_erase(input bit with_req);
    @(negedge clk);
    erase_req = 1'b1;
    req_valid = with_req; req_op = 3'd3; req_wdata = 8'h07; req_addr = 8'h10;
    @(negedge clk);
    erase_req = 1'b0; req_valid = 1'b0;
    model_erase();
    chk("R10", int'(rsp_valid), 0);
    chk("R10", int'(access_denied), 0);
    chk("R10", int'(level), 0);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R11", int'(access_denied), 0);
    chk("R11", int'(rsp_valid), 0);
  endtask

  bit done = 1'b0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_erase();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R1", int'(level), 0);
    chk("R5", int'(ext_exec_en), 1);
    chk("R11", int'(rsp_valid), 0);
    chk("R11", int'(access_denied), 0);

    // Level 0: everything granted, erased key gives plain verify
    do_req(3'd0, 8'h85, 8'h35, "R2");
    do_req(3'd4, 8'h85, 8'h00, "R7");
    do_req(3'd1, 8'h02, 8'hA6, "R2");
    do_req(3'd2, 8'h05, 8'h0F, "R2");
    do_req(3'd4, 8'h85, 8'h00, "R7");
    chk("R7", int'(rsp_data), 8'hC5);
    do_req(3'd7, 8'h85, 8'h00, "R8");

    // Raise to level 1, programming locked, downgrade refused
    do_req(3'd3, 8'h00, 8'h01, "R9");
    do_req(3'd0, 8'h85, 8'h99, "R3");
    do_req(3'd2, 8'h05, 8'h11, "R3");
    idle_check();
    do_req(3'd7, 8'h85, 8'h00, "R3");
    do_req(3'd4, 8'h05, 8'h00, "R7");
    do_req(3'd3, 8'h00, 8'h00, "R9");
    // Level 2 and 3
    do_req(3'd3, 8'h00, 8'h03, "R9");
    do_req(3'd4, 8'h85, 8'h00, "R4");
    idle_check();
    do_req(3'd3, 8'h00, 8'h01, "R9");
    do_req(3'd3, 8'h00, 8'h04, "R5");
    do_req(3'd5, 8'h02, 8'h00, "R6");
    do_req(3'd6, 8'h00, 8'h00, "R6");
    do_req(3'd7, 8'h85, 8'h00, "R8");
    // Erase with a competing request
    do_erase(1'b1);
    do_req(3'd7, 8'h85, 8'h00, "R10");
    do_req(3'd4, 8'h05, 8'h00, "R10");

    // Constrained random phase
    for (int n = 0; n < 1500; n++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      logic [7:0] ad = 8'($urandom);
      logic [7:0] wd = 8'($urandom);
      if (op == 3'd3 && $urandom_range(0, 2) != 0) wd[2:0] = 3'($urandom_range(0, 2));
      if ($urandom_range(0, 60) == 0 || (lvl_of(lb_m) == 3 && $urandom_range(0, 10) == 0))
        do_erase(1'($urandom_range(0, 1)));
      else
        do_req(op, ad, wd, "");
      if ($urandom_range(0, 9) == 0) idle_check();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule